// File: doc/BRIEF.md
# HDLC Manchester Frame Receiver

This block turns an oversampled, Manchester-coded serial line back into a frame of data. It decodes each bit from the direction of its mid-bit transition. It finds frame boundaries from flag octets and strips the zero bits the sender inserted after runs of ones. The resulting bit stream is then parsed as sixteen-bit words sent most significant bit first. The first word must be a fixed header. After it come one to fifteen blocks, and each block holds eight data words and a check word covering those eight words.

Words are collected in a staging store while the frame arrives. When the closing flag shows the frame was complete and every check passed, the whole staging store is copied to the parallel block outputs in one step. The block count is updated at the same time, and a single-cycle valid pulse marks the update. A frame that fails any check leaves the outputs untouched and raises a single-cycle error pulse instead. The block is meant to feed a controller that polls the latest block set whenever the valid pulse appears.

Top module: `hdlc_frame_rx`

## Requirements
- R1: The line is sampled OSR times per bit and idles high. A rising transition at mid-bit decodes as 1 and a falling one as 0. Edges at bit boundaries are ignored, and each sixteen-bit word is sent most significant bit first.
- R2: The octet 0x7E (bits 0,1,1,1,1,1,1,0) is a frame delimiter. The bits between two flags form one frame, and back-to-back flags with nothing between them produce no pulse.
- R3: Inside a frame, a 0 that follows five consecutive 1s is removed before parsing, so data words such as 0xFFFF or 0x7E7E arrive intact.
- R4: The first word of a frame must equal 0x0564; any other value discards the frame with an error pulse.
- R5: Each block's check word must equal the bitwise complement of a CRC over its eight data words, with polynomial 0x3D65, seed 0x0000, processed most significant bit first. A mismatch in any block discards the frame with an error pulse.
- R6: Block k (k = 0..14) occupies blk_data_o[128k+127:128k], with word Rj at bits [128k+16j+15:128k+16j]. Blocks past the received count read zero after a valid frame.
- R7: blk_cnt_o holds the number of blocks in the last valid frame, which is between 1 and 15.
- R8: frame_vld_o is high for exactly one cycle. It rises on the same clock edge that loads the new block outputs and count, and the block outputs change at no other time.
- R9: A frame whose length after the header is not a whole number of blocks is discarded with an error pulse. This includes a frame with only the header, or one that ends inside a word.
- R10: A frame with more than 15 blocks is discarded with an error pulse.
- R11: Seven or more consecutive 1s abort a frame that has started, giving an error pulse. Reception resumes at the next flag.
- R12: frame_err_o is a one-cycle pulse that never coincides with frame_vld_o. On an error, the block outputs and count keep their previous values.
- R13: After reset, all block outputs, the count and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OSR cycles per bit |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Manchester-coded serial line |
| blk_data_o | output | MAX_BLK*128 | Received blocks, block 0 in the lowest 128 bits |
| blk_cnt_o | output | $clog2(MAX_BLK+1) | Block count of the last valid frame |
| frame_vld_o | output | 1 | One-cycle pulse when new blocks are published |
| frame_err_o | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
Some properties are checked by assertions on every cycle. Decoded bits never arrive on adjacent cycles. The delimiter, abort and data strobes from the unstuffing stage are mutually exclusive. The valid and error pulses last one cycle and never overlap. The block outputs change only together with a valid pulse, and that pulse always carries a count from 1 to 15. Other behaviour can only be shown by the bench's scenarios. These cover bit-exact decoding of each block position across a sweep of every frame length from 1 to 15 blocks, with data full of stuffing runs. They also show that header, CRC, truncation, overlength and abort errors each leave the previously published blocks in place.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int          WORD_W   = 16;
    localparam int          WPB      = 8;                 // data words per block
    localparam int          BLK_W    = WORD_W * WPB;
    localparam int          FLAG_LEN = 8;
    localparam logic [15:0] HDR_WORD = 16'h0564;
    localparam logic [15:0] CRC_POLY = 16'h3D65;

    // one CRC step, most significant bit first
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        crc_step = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction
endpackage

// File: rtl/hdlc_manch_dec.sv
module hdlc_manch_dec #(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic bit_vld_o,
    output logic bit_o
);
    localparam int THR  = (3 * OSR) / 4;
    localparam int CMAX = 2 * OSR;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          prev;
        logic [CW-1:0] cnt;
        logic          vld;
        logic          bitv;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d      = dec_q;
        dec_d.sync = {dec_q.sync[0], line_i};
        dec_d.prev = dec_q.sync[1];
        dec_d.vld  = 1'b0;
        if (dec_q.sync[1] != dec_q.prev && dec_q.cnt >= CW'(THR)) begin
            // mid-bit transition: new level is the bit value
            dec_d.vld  = 1'b1;
            dec_d.bitv = dec_q.sync[1];
            dec_d.cnt  = '0;
        end else if (dec_q.cnt != CW'(CMAX)) begin
            dec_d.cnt = dec_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q      <= '0;
            dec_q.sync <= 2'b11;
            dec_q.prev <= 1'b1;
            dec_q.cnt  <= CW'(CMAX);
        end else begin
            dec_q <= dec_d;
        end
    end

    assign bit_vld_o = dec_q.vld;
    assign bit_o     = dec_q.bitv;

    // R1
    bit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |=> !bit_vld_o);
endmodule

// File: rtl/hdlc_unstuff.sv
module hdlc_unstuff
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld_i,
    input  logic in_bit_i,
    output logic bit_vld_o,
    output logic bit_o,
    output logic flag_o,
    output logic abort_o
);
    localparam int DLY = FLAG_LEN - 1;
    localparam int HW  = $clog2(DLY + 1);

    typedef struct packed {
        logic [2:0]     ones;
        logic [DLY-1:0] dly;
        logic [HW-1:0]  held;
        logic           vld;
        logic           bitv;
        logic           flag;
        logic           abort;
    } us_t;

    us_t us_d, us_q;

    always_comb begin
        us_d       = us_q;
        us_d.vld   = 1'b0;
        us_d.flag  = 1'b0;
        us_d.abort = 1'b0;
        if (in_vld_i) begin
            if (us_q.ones == 3'd5 && !in_bit_i) begin
                us_d.ones = '0;                       // stuffed zero dropped
            end else if (us_q.ones == 3'd6 && !in_bit_i) begin
                us_d.flag = 1'b1;                     // delimiter; held bits belong to it
                us_d.ones = '0;
                us_d.held = '0;
            end else if (us_q.ones >= 3'd6 && in_bit_i) begin
                us_d.abort = (us_q.ones == 3'd6);
                us_d.ones  = 3'd7;
                us_d.held  = '0;
            end else if (us_q.ones == 3'd7 && !in_bit_i) begin
                us_d.ones = '0;
                us_d.held = '0;
            end else begin
                us_d.ones = in_bit_i ? us_q.ones + 1'b1 : 3'd0;
                if (us_q.held == HW'(DLY)) begin
                    us_d.vld  = 1'b1;
                    us_d.bitv = us_q.dly[DLY-1];
                end else begin
                    us_d.held = us_q.held + 1'b1;
                end
                us_d.dly = {us_q.dly[DLY-2:0], in_bit_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) us_q <= '0;
        else     us_q <= us_d;
    end

    assign bit_vld_o = us_q.vld;
    assign bit_o     = us_q.bitv;
    assign flag_o    = us_q.flag;
    assign abort_o   = us_q.abort;

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_o, abort_o, bit_vld_o}));
endmodule

// File: rtl/hdlc_blk_asm.sv
module hdlc_blk_asm
    import hdlc_rx_pkg::*;
#(
    parameter int MAX_BLK = 15
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_vld_i,
    input  logic                        bit_i,
    input  logic                        flag_i,
    input  logic                        abort_i,
    output logic [MAX_BLK*BLK_W-1:0]    blk_data_o,
    output logic [$clog2(MAX_BLK+1)-1:0] blk_cnt_o,
    output logic                        frame_vld_o,
    output logic                        frame_err_o
);
    localparam int CW  = $clog2(MAX_BLK + 1);
    localparam int WIW = $clog2(WPB + 1);
    localparam int WSW = $clog2(WPB);

    typedef logic [MAX_BLK-1:0][WPB-1:0][WORD_W-1:0] blkset_t;

    typedef struct packed {
        logic        in_frm;
        logic        any;
        logic        bad;
        logic        hdr_ok;
        logic [3:0]  bitpos;
        logic [WIW-1:0] widx;
        logic [CW-1:0]  nblk;
        logic [15:0] shreg;
        logic [15:0] crc;
        blkset_t     stage;
        blkset_t     blks;
        logic [CW-1:0] cnt;
        logic        vld;
        logic        err;
    } asm_t;

    asm_t as_d, as_q;
    logic [15:0] word_w;

    always_comb begin
        as_d     = as_q;
        as_d.vld = 1'b0;
        as_d.err = 1'b0;
        word_w   = {as_q.shreg[14:0], bit_i};
        if (flag_i) begin
            if (as_q.in_frm && as_q.any) begin
                if (!as_q.bad && as_q.hdr_ok && as_q.bitpos == 4'd0 &&
                    as_q.widx == '0 && as_q.nblk != '0) begin
                    as_d.blks = as_q.stage;
                    as_d.cnt  = as_q.nblk;
                    as_d.vld  = 1'b1;
                end else begin
                    as_d.err = 1'b1;
                end
            end
            as_d.in_frm = 1'b1;
            as_d.any    = 1'b0;
            as_d.bad    = 1'b0;
            as_d.hdr_ok = 1'b0;
            as_d.bitpos = '0;
            as_d.widx   = '0;
            as_d.nblk   = '0;
            as_d.shreg  = '0;
            as_d.crc    = '0;
            as_d.stage  = '0;
        end else if (abort_i) begin
            if (as_q.in_frm && as_q.any) as_d.err = 1'b1;
            as_d.in_frm = 1'b0;
        end else if (bit_vld_i && as_q.in_frm) begin
            as_d.any    = 1'b1;
            as_d.shreg  = word_w;
            as_d.bitpos = as_q.bitpos + 1'b1;
            // a further word after the last allowed block: overlength
            if (as_q.hdr_ok && as_q.widx == '0 && as_q.bitpos == 4'd0 &&
                as_q.nblk == CW'(MAX_BLK))
                as_d.bad = 1'b1;
            if (as_q.hdr_ok && as_q.widx < WIW'(WPB))
                as_d.crc = crc_step(as_q.crc, bit_i);
            if (as_q.bitpos == 4'd15) begin
                if (!as_q.hdr_ok) begin
                    as_d.hdr_ok = 1'b1;
                    if (word_w != HDR_WORD) as_d.bad = 1'b1;
                end else if (as_q.widx < WIW'(WPB)) begin
                    if (as_q.nblk < CW'(MAX_BLK))
                        as_d.stage[as_q.nblk][as_q.widx[WSW-1:0]] = word_w;
                    as_d.widx = as_q.widx + 1'b1;
                end else begin
                    if (word_w != ~as_q.crc) as_d.bad = 1'b1;
                    as_d.crc  = '0;
                    as_d.widx = '0;
                    if (as_q.nblk < CW'(MAX_BLK)) as_d.nblk = as_q.nblk + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) as_q <= '0;
        else     as_q <= as_d;
    end

    assign blk_data_o  = as_q.blks;
    assign blk_cnt_o   = as_q.cnt;
    assign frame_vld_o = as_q.vld;
    assign frame_err_o = as_q.err;

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |=> !frame_vld_o);
    // R12
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);
    // R12
    vld_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_vld_o, frame_err_o}));
    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(blk_data_o) |-> frame_vld_o);
    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |-> (blk_cnt_o != '0 && blk_cnt_o <= CW'(MAX_BLK)));
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
    import hdlc_rx_pkg::*;
#(
    parameter int OSR     = 8,
    parameter int MAX_BLK = 15
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         line_i,
    output logic [MAX_BLK*BLK_W-1:0]     blk_data_o,
    output logic [$clog2(MAX_BLK+1)-1:0] blk_cnt_o,
    output logic                         frame_vld_o,
    output logic                         frame_err_o
);
    logic raw_vld, raw_bit;
    logic dat_vld, dat_bit, flag, abort;

    hdlc_manch_dec #(.OSR(OSR)) i_dec (
        .clk       (clk),
        .rst       (rst),
        .line_i    (line_i),
        .bit_vld_o (raw_vld),
        .bit_o     (raw_bit)
    );

    hdlc_unstuff i_unstuff (
        .clk       (clk),
        .rst       (rst),
        .in_vld_i  (raw_vld),
        .in_bit_i  (raw_bit),
        .bit_vld_o (dat_vld),
        .bit_o     (dat_bit),
        .flag_o    (flag),
        .abort_o   (abort)
    );

    hdlc_blk_asm #(.MAX_BLK(MAX_BLK)) i_asm (
        .clk         (clk),
        .rst         (rst),
        .bit_vld_i   (dat_vld),
        .bit_i       (dat_bit),
        .flag_i      (flag),
        .abort_i     (abort),
        .blk_data_o  (blk_data_o),
        .blk_cnt_o   (blk_cnt_o),
        .frame_vld_o (frame_vld_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: tb/test_hdlc_frame_rx.sv
module test_hdlc_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OSR  = 4;
    localparam int MAXB = 15;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  line = 1'b1;
    logic [MAXB*128-1:0]   blk_data;
    logic [3:0]            blk_cnt;
    logic                  fvld, ferr;

    int checks = 0;
    int errors = 0;
    int nvld = 0;
    int nerr = 0;
    int cycles = 0;
    int ones_run = 0;

    logic [15:0] tx [0:159];
    int          tx_len;
    logic [15:0] exp_w [0:MAXB-1][0:7];
    int          exp_cnt = 0;

    hdlc_frame_rx #(.OSR(OSR), .MAX_BLK(MAXB)) i_hdlc_frame_rx (
        .clk(clk), .rst(rst), .line_i(line),
        .blk_data_o(blk_data), .blk_cnt_o(blk_cnt),
        .frame_vld_o(fvld), .frame_err_o(ferr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (!rst && fvld) nvld++;
        if (!rst && ferr) nerr++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_words(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        logic fb;
        r = c;
        for (int i = 15; i >= 0; i--) begin
            fb = r[15] ^ w[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h3D65;
        end
        return r;
    endfunction

    function automatic logic [15:0] gen(input int n, input int b, input int j);
        case (n % 3)
            0: return 16'hFFFF;
            1: return 16'h7E7E ^ 16'(b << 8) ^ 16'(j);
            default: return 16'(b * 16'h1111 + j * 16'h0203 + n);
        endcase
    endfunction

    task automatic half(input logic lv);
        repeat (OSR/2) begin
            @(negedge clk);
            line = lv;
        end
    endtask

    // R1: 1 = low then high, 0 = high then low
    task automatic send_raw(input logic b);
        half(~b);
        half(b);
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        ones_run = 0;
    endtask

    // R3: sender inserts a zero after five ones
    task automatic send_data(input logic b);
        send_raw(b);
        ones_run = b ? ones_run + 1 : 0;
        if (ones_run == 5) begin
            send_raw(1'b0);
            ones_run = 0;
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_data(w[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            line = 1'b1;
        end
    endtask

    task automatic build(input int n, input int pat);
        logic [15:0] c;
        tx[0] = 16'h0564;
        tx_len = 1;
        for (int b = 0; b < n; b++) begin
            c = 16'h0000;
            for (int j = 0; j < 8; j++) begin
                tx[tx_len] = gen(pat, b, j);
                c = crc_words(c, tx[tx_len]);
                tx_len++;
            end
            tx[tx_len] = ~c;
            tx_len++;
        end
    endtask

    task automatic send_frame();
        send_flag();
        send_flag();
        for (int k = 0; k < tx_len; k++) send_word(tx[k]);
        send_flag();
        idle(20);
    endtask

    task automatic check_outputs(input string req);
        logic [127:0] e;
        chk(blk_cnt == 4'(exp_cnt), {req, " count"}, 128'(blk_cnt), 128'(exp_cnt));
        for (int b = 0; b < MAXB; b++) begin
            for (int j = 0; j < 8; j++) e[j*16 +: 16] = (b < exp_cnt) ? exp_w[b][j] : 16'h0;
            chk(blk_data[b*128 +: 128] == e, req, blk_data[b*128 +: 128], e);
        end
    endtask

    task automatic expect_ok(input int n, input int pat, input string req);
        int v0, e0;
        v0 = nvld;
        e0 = nerr;
        build(n, pat);
        send_frame();
        for (int b = 0; b < MAXB; b++)
            for (int j = 0; j < 8; j++) exp_w[b][j] = (b < n) ? gen(pat, b, j) : 16'h0;
        exp_cnt = n;
        chk(nvld == v0 + 1, {req, " valid pulse"}, 128'(nvld - v0), 128'(1));
        chk(nerr == e0, {req, " no error"}, 128'(nerr - e0), 128'(0));
        check_outputs(req);
    endtask

    task automatic expect_err(input string req);
        int v0, e0;
        v0 = nvld;
        e0 = nerr;
        send_frame();
        chk(nerr == e0 + 1, {req, " error pulse"}, 128'(nerr - e0), 128'(1));
        chk(nvld == v0, {req, " no valid"}, 128'(nvld - v0), 128'(0));
        check_outputs({req, " outputs kept R12"});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(blk_data == '0, "R13 data", blk_data[127:0], 128'(0));
        chk(blk_cnt == 4'd0 && !fvld && !ferr, "R13 count/pulses",
            128'({blk_cnt, fvld, ferr}), 128'(0));

        // R2: two bare flags give no pulse
        send_flag();
        send_flag();
        idle(20);
        chk(nvld == 0 && nerr == 0, "R2 empty frame", 128'(nvld + nerr), 128'(0));

        // R1 R3 R5 R6 R7 R8: every frame length with stuffing-heavy patterns
        for (int n = 1; n <= MAXB; n++) expect_ok(n, n, "R6 R7 sweep");

        // R4 bad header
        build(3, 2);
        tx[0] = 16'h0565;
        expect_err("R4 header");

        // R5 corrupted check word of block 0
        build(2, 1);
        tx[9] = tx[9] ^ 16'h0001;
        expect_err("R5 check word");

        // R5 corrupted data word in block 1
        build(2, 2);
        tx[12] = tx[12] ^ 16'h0100;
        expect_err("R5 data word");

        // R9 frame ending mid-block
        build(2, 2);
        tx_len = tx_len - 3;
        expect_err("R9 partial block");

        // R9 header only
        build(1, 2);
        tx_len = 1;
        expect_err("R9 header only");

        // R10 sixteen blocks
        build(16, 1);
        expect_err("R10 overlength");

        // R11 abort after a few words
        begin
            int v0, e0;
            v0 = nvld;
            e0 = nerr;
            build(2, 2);
            send_flag();
            for (int k = 0; k < 5; k++) send_word(tx[k]);
            repeat (8) send_raw(1'b1);
            idle(20);
            chk(nerr == e0 + 1, "R11 abort error", 128'(nerr - e0), 128'(1));
            chk(nvld == v0, "R11 abort no valid", 128'(nvld - v0), 128'(0));
            check_outputs("R11 outputs kept");
        end

        // R11 recovery at next flag
        expect_ok(4, 2, "R11 recovery");
        expect_ok(1, 0, "R3 all-ones block");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule